// File: doc/BRIEF.md
# Three-Slot Age-Ordered Frame Receive Buffer

This block sits between a serial bus receiver front end and a host. The front end marks the start and the end of each incoming message frame with single-cycle strobes, and it delivers the bytes between those strobes. Each complete frame is stored in one of three independent slots. The first byte of a frame is its header. Each slot also keeps the byte length of its frame. For every slot the block keeps a 2-bit age rank and packs the three ranks into one status word. Software can therefore drain the slots oldest-first without any FIFO pointers.

The host reads a slot's length and its bytes through a small combinational read port. Each slot has its own ready flag, which is meant to drive a separate interrupt line. A 4-bit control write releases slots and selects the operating mode. Mode 1 uses all three slots. Mode 0 uses only slot 0.

Top module: `rx_frame_slots`

## Requirements
- R1: A synchronous active-high reset leaves the block as follows: all ranks 0, all ready flags low, overflow low, single-slot mode selected (mode bit 0) and every control clear bit at 0.
- R2: `rank_status` holds the rank of slot 0 in bits [1:0], slot 1 in bits [3:2] and slot 2 in bits [5:4]. A rank of 0 means the slot is empty. Ranks 1, 2 and 3 mean the oldest, second-oldest and third-oldest stored frame.
- R3: A completed frame is stored in the lowest-numbered slot that is empty and usable. Its rank is the number of occupied slots plus one, with any release in the same cycle applied first. The slot's rank changes on the clock edge that samples `rx_eof`.
- R4: `buf_ready[i]` is high exactly while slot i holds a frame. It rises only on the edge that samples an end-of-frame strobe.
- R5: In a control write, `ctrl_wdata[2:0]` are per-slot clear bits. When a clear bit goes from 0 to 1, that slot is emptied. While the bit stays 1, the slot takes no frame. After the bit is written back to 0, the slot accepts frames again.
- R6: When slots are released, every remaining occupied slot of higher rank drops its rank by the number of released slots below it. The ranks therefore stay contiguous from 1.
- R7: `ctrl_wdata[3]` selects the mode: 1 uses all three slots, 0 uses slot 0 only. A write with bit 3 at 0 also empties slots 1 and 2, which then keep rank 0.
- R8: A non-empty frame that finds no usable empty slot is dropped and sets `overflow`. The flag stays high until reset.
- R9: A slot stores at most 16 bytes. Further bytes are discarded and the stored length saturates at 16.
- R10: A frame that ends with zero bytes received is discarded. It uses no slot and does not set overflow.
- R11: `rd_len` gives the stored length of slot `rd_buf`. `rd_data` gives the byte at index `rd_addr` of that slot, where index 0 is the header. Both are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sof | input | 1 | Start-of-frame strobe |
| rx_byte_vld | input | 1 | Byte valid strobe |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | End-of-frame strobe |
| ctrl_we | input | 1 | Control write enable |
| ctrl_wdata | input | 4 | Bits [2:0] are clear bits, bit 3 is the mode |
| rd_buf | input | 2 | Slot selected for reading |
| rd_addr | input | 4 | Byte index within the slot |
| rd_data | output | 8 | Selected byte |
| rd_len | output | 5 | Stored length of the selected slot |
| rank_status | output | 6 | Packed age ranks |
| buf_ready | output | 3 | Per-slot ready flags |
| overflow | output | 1 | Sticky dropped-frame flag |

## Verification
The assertions assume that the front end brackets every frame with a start strobe and then an end strobe. They also assume that bytes arrive only in the cycles between those two strobes, never in the start cycle itself. The ready-flag check depends on this ordering, because it traces each rise of a flag back to an end strobe. The bench drives start, byte and end pulses in separate cycles, always in that order. It issues control writes only while no frame is in progress. Under that stimulus, each slot release and each completion can be tied to a single clock edge.

// File: rtl/rx_frame_slots.sv
module rx_frame_slots #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_sof,
  input  logic        rx_byte_vld,
  input  logic [7:0]  rx_byte,
  input  logic        rx_eof,
  input  logic        ctrl_we,
  input  logic [3:0]  ctrl_wdata,
  input  logic [1:0]  rd_buf,
  input  logic [3:0]  rd_addr,
  output logic [7:0]  rd_data,
  output logic [4:0]  rd_len,
  output logic [5:0]  rank_status,
  output logic [2:0]  buf_ready,
  output logic        overflow
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [3][DEPTH];
  logic [1:0]    rank_q [3];
  logic [LW-1:0] len_q [3];
  logic [2:0]    clr_q;
  logic          mode_q, busy_q, tgt_ok_q, ovf_q;
  logic [1:0]    tgt_q;
  logic [LW-1:0] cnt_q;

  logic [2:0]    clr_nx, rel, avail;
  logic          mode_nx;
  logic [1:0]    rk_rel [3];
  logic [1:0]    nfull, pick;
  logic          any_avail, byte_take, commit, drop;
  logic [LW-1:0] cnt_end;

  assign clr_nx  = ctrl_we ? ctrl_wdata[2:0] : clr_q;
  assign mode_nx = ctrl_we ? ctrl_wdata[3] : mode_q;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      rel[i]   = ctrl_we && ((ctrl_wdata[i] && !clr_q[i]) || (i != 0 && !ctrl_wdata[3]));
      avail[i] = rank_q[i] == 2'd0 && !clr_q[i] && (mode_q || i == 0);
    end
    nfull = 2'd0;
    for (int i = 0; i < 3; i++) begin
      logic [1:0] dec;
      dec = 2'd0;
      for (int j = 0; j < 3; j++)
        if (rel[j] && rank_q[j] != 2'd0 && rank_q[j] < rank_q[i]) dec = dec + 2'd1;
      rk_rel[i] = rel[i] ? 2'd0 : rank_q[i] - dec;
      if (rk_rel[i] != 2'd0) nfull = nfull + 2'd1;
    end
    pick = 2'd0;
    for (int i = 2; i >= 0; i--)
      if (avail[i]) pick = 2'(i);
  end

  assign any_avail = |avail;
  assign byte_take = busy_q && rx_byte_vld && (cnt_q < LW'(DEPTH));
  assign cnt_end   = cnt_q + LW'(byte_take);
  assign commit    = busy_q && rx_eof && tgt_ok_q && cnt_end != '0 &&
                     !clr_nx[tgt_q] && (mode_nx || tgt_q == 2'd0);
  assign drop      = busy_q && rx_eof && cnt_end != '0 && !commit;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_q    <= '0;
      mode_q   <= 1'b0;
      busy_q   <= 1'b0;
      tgt_ok_q <= 1'b0;
      tgt_q    <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
      for (int i = 0; i < 3; i++) begin
        rank_q[i] <= '0;
        len_q[i]  <= '0;
      end
    end else begin
      clr_q  <= clr_nx;
      mode_q <= mode_nx;
      for (int i = 0; i < 3; i++) rank_q[i] <= rk_rel[i];
      if (commit) begin
        rank_q[tgt_q] <= nfull + 2'd1;
        len_q[tgt_q]  <= cnt_end;
      end
      if (drop) ovf_q <= 1'b1;
      if (rx_sof) begin
        busy_q   <= 1'b1;
        cnt_q    <= '0;
        tgt_q    <= pick;
        tgt_ok_q <= any_avail;
      end else begin
        if (rx_eof) busy_q <= 1'b0;
        if (byte_take) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (!rst && !rx_sof && byte_take && tgt_ok_q)
      mem[tgt_q][AW'(cnt_q)] <= rx_byte;

  assign rank_status = {rank_q[2], rank_q[1], rank_q[0]};
  assign overflow    = ovf_q;
  assign rd_len      = (rd_buf == 2'd3) ? 5'd0 : 5'(len_q[rd_buf]);
  assign rd_data     = (rd_buf == 2'd3) ? 8'd0 : mem[rd_buf][AW'(rd_addr)];

  for (genvar g = 0; g < 3; g++) begin : g_rdy
    assign buf_ready[g] = rank_q[g] != 2'd0;
    p_ready_on_eof_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(buf_ready[g]) |-> $past(rx_eof));
    p_len_sat_r9: assert property (@(posedge clk) disable iff (rst)
      len_q[g] <= LW'(DEPTH));
  end

  logic [1:0] chk_n;
  logic [3:0] chk_sum;
  assign chk_n   = 2'(buf_ready[0]) + 2'(buf_ready[1]) + 2'(buf_ready[2]);
  assign chk_sum = 4'(rank_q[0]) + 4'(rank_q[1]) + 4'(rank_q[2]);

  p_rank_contig_r6: assert property (@(posedge clk) disable iff (rst)
    chk_sum == ((4'(chk_n) * (4'(chk_n) + 4'd1)) >> 1) &&
    (rank_q[0] == 2'd0 || rank_q[0] != rank_q[1]) &&
    (rank_q[0] == 2'd0 || rank_q[0] != rank_q[2]) &&
    (rank_q[1] == 2'd0 || rank_q[1] != rank_q[2]));
  p_legacy_slots_r7: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> (rank_q[1] == 2'd0 && rank_q[2] == 2'd0));
  p_sticky_ovf_r8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  p_held_clear_r5: assert property (@(posedge clk) disable iff (rst)
    $past(clr_q[0]) && clr_q[0] |-> rank_q[0] == 2'd0);
endmodule

// File: tb/rx_frame_slots_tb_top.sv
module rx_frame_slots_tb_top;
  logic clk = 0, rst = 1;
  logic rx_sof = 0, rx_byte_vld = 0, rx_eof = 0, ctrl_we = 0;
  logic [7:0] rx_byte = 0;
  logic [3:0] ctrl_wdata = 0, rd_addr = 0;
  logic [1:0] rd_buf = 0;
  logic [7:0] rd_data;
  logic [4:0] rd_len;
  logic [5:0] rank_status;
  logic [2:0] buf_ready, prev_rdy;
  logic overflow;
  int checks = 0, fails = 0;
  int exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  rx_frame_slots dut_i (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctrl_wr(logic [3:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic send(int n, logic [7:0] base, int exp_buf);
    @(negedge clk); rx_sof = 1;
    @(negedge clk); rx_sof = 0;
    for (int k = 0; k < n; k++) begin
      rx_byte_vld = 1; rx_byte = base + 8'(k);
      @(negedge clk);
    end
    rx_byte_vld = 0;
    if (exp_buf >= 0) exp_q.push_back(exp_buf);
    rx_eof = 1;
    @(negedge clk); rx_eof = 0;
  endtask

  task automatic rd(logic [1:0] b, logic [3:0] a);
    rd_buf = b; rd_addr = a; #1;
  endtask

  always @(negedge clk) begin
    if (rst) prev_rdy <= '0;
    else begin
      for (int i = 0; i < 3; i++)
        if (buf_ready[i] && !prev_rdy[i]) begin
          if (exp_q.size() == 0) chk("R4 unexpected ready", i, -1);
          else chk("R4 ready slot", i, exp_q.pop_front());
        end
      prev_rdy <= buf_ready;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 status", rank_status, 0);
    chk("R1 ready", buf_ready, 0);
    chk("R1 overflow", overflow, 0);
    send(3, 8'hA0, 0);
    chk("R7 legacy slot0", rank_status, 6'h01);
    send(2, 8'hB0, -1);
    chk("R8 drop status", rank_status, 6'h01);
    chk("R8 overflow", overflow, 1);
    ctrl_wr(4'hF);
    chk("R5 clear", rank_status, 0);
    ctrl_wr(4'h8);
    send(0, 8'h00, -1);
    chk("R10 empty frame", rank_status, 0);
    send(2, 8'h10, 0);
    send(20, 8'h40, 1);
    send(1, 8'h70, 2);
    chk("R2 R3 packed ranks", rank_status, 6'h39);
    rd(2'd1, 4'd0);
    chk("R9 len sat", rd_len, 16);
    rd(2'd1, 4'd15);
    chk("R9 last byte", rd_data, 8'h4F);
    rd(2'd0, 4'd1);
    chk("R11 data", rd_data, 8'h11);
    chk("R11 len", rd_len, 2);
    ctrl_wr(4'h9);
    chk("R6 decrement", rank_status, 6'h24);
    send(2, 8'h80, -1);
    chk("R5 held clear", rank_status, 6'h24);
    ctrl_wr(4'h8);
    send(4, 8'h90, 0);
    chk("R3 rank count", rank_status, 6'h27);
    ctrl_wr(4'hA);
    chk("R6 mid release", rank_status, 6'h12);
    ctrl_wr(4'h8);
    send(1, 8'hC0, 1);
    chk("R3 lowest empty", rank_status, 6'h1E);
    rd(2'd0, 4'd0);
    chk("R11 header", rd_data, 8'h90);
    ctrl_wr(4'h0);
    chk("R7 legacy release", rank_status, 6'h01);
    repeat (2) @(negedge clk);
    chk("R4 queue drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule